// File: doc/BRIEF.md
# Shuffled-Order Modular Exponentiator

This block computes `msg^expo mod modulus` for small parameterised operand widths. The order in which the exponent's bits are consumed is hidden behind a fresh random permutation on every run. The work runs in four stages, strictly in sequence:

1. A chain of modular squarings fills a power table whose entry i holds `msg^(2^i) mod modulus`.
2. An index permutation is drawn. It is a Fisher–Yates shuffle fed by a seeded LFSR with rejection sampling, and it re-pairs every table entry with its exponent bit.
3. One pass over the permuted positions sorts each index into a list of one-positions or a list of zero-positions.
4. An accumulator starting at 1 is multiplied by the table entry behind every one-list entry, with no per-bit decision.

A single iterative shift-and-add modular multiplier serves both the squaring stage and the accumulation stage.

The user pulses `start` with the operands and a seed. After some time `done` pulses and `result` holds the value until the next run completes. Each stage-4 multiply is flagged on `mul_tick`. This makes the length of the accumulation loop visible at the ports.

Top module: `psa_modexp`

## Requirements
- R1: After reset, `done` and `mul_tick` are low and `result` is 0.
- R2: For `modulus` >= 2 and any `msg` (including `msg` >= `modulus`) and `expo`, the `result` delivered with `done` equals `msg^expo mod modulus`.
- R3: The result does not depend on `seed`. Every permutation of the power table and exponent bits yields the same value.
- R4: Between a start and its `done`, `mul_tick` pulses exactly popcount(`expo`) times, one per multiply in the accumulation stage. Zero bits cause no accumulation multiply.
- R5: With `expo` = 0 the block returns 1 and `mul_tick` never pulses.
- R6: `done` is a single-cycle pulse, given once per accepted start. `result` keeps its value until the next `done`.
- R7: A `start` pulse that arrives while a run is in progress is ignored. It changes neither the current result nor causes an extra `done`.
- R8: `result` is always less than `modulus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run; operands are captured in this cycle when idle |
| msg | input | W | Base |
| expo | input | M | Exponent |
| modulus | input | W | Modulus, must be at least 2 |
| seed | input | LW | Mixed into the LFSR on every accepted start |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Registered exponentiation result |
| mul_tick | output | 1 | One-cycle pulse per accumulation-stage multiply |

## Verification
The bench aims at a zero exponent. A design that entered the loop anyway, or started the accumulator from the table, would return a power of `msg` instead of 1, or pulse `mul_tick`. It aims at a base larger than the modulus, which breaks a multiplier that assumes reduced inputs. It also reuses the same operands under several seeds, so that a shuffle which breaks the bit-to-power pairing shows up as a seed-dependent answer. Single-bit and all-ones exponents check that the tick count tracks the Hamming weight, and a start injected mid-run checks that the captured operands are not overwritten.

// File: rtl/psa_pkg.sv
package psa_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE_GO, S_PRE_WAIT, S_SHUF, S_SCAN,
    S_ACC_RD, S_ACC_TB, S_ACC_MUL, S_ACC_WAIT, S_FIN
  } state_t;
endpackage

// File: rtl/psa_lfsr.sv
module psa_lfsr #(
  parameter int LW = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] seed,
  input  logic          step,
  output logic [LW-1:0] q
);
  logic [LW-1:0] mixed;
  assign mixed = q ^ seed;

  always_ff @(posedge clk) begin
    if (rst) q <= LW'(1);
    else if (load) q <= (mixed == '0) ? LW'(1) : mixed;
    else if (step) q <= (q >> 1) ^ (q[0] ? TAPS : '0);
  end
endmodule

// File: rtl/psa_modmul.sv
module psa_modmul #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] p,
  output logic [W-1:0] y,
  output logic         rdy
);
  localparam int CNTW = $clog2(W + 1);
  logic [W-1:0]    a_q, b_q, p_q;
  logic [CNTW-1:0] cnt;
  logic            busy;
  logic [W:0]      dbl, dbl_r, sum, sum_r;

  // y is always kept reduced: doubling then adding a (< p) stays under 2p
  always_comb begin
    dbl   = {y, 1'b0};
    dbl_r = (dbl >= {1'b0, p_q}) ? dbl - {1'b0, p_q} : dbl;
    sum   = dbl_r + (b_q[W-1] ? {1'b0, a_q} : '0);
    sum_r = (sum >= {1'b0, p_q}) ? sum - {1'b0, p_q} : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; b_q <= '0; p_q <= '0; y <= '0;
      cnt <= '0; busy <= 1'b0; rdy <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (go) begin
        a_q <= a; b_q <= b; p_q <= p; y <= '0;
        cnt <= CNTW'(W); busy <= 1'b1;
      end else if (busy) begin
        y   <= sum_r[W-1:0];
        b_q <= b_q << 1;
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) begin
          busy <= 1'b0;
          rdy  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psa_idxlist.sv
module psa_idxlist #(
  parameter int DEPTH = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [AW-1:0] din,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] rd_data,
  output logic [AW:0]   count
);
  logic [AW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push) mem[count[AW-1:0]] <= din;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (push)  count <= count + 1'b1;
  end
endmodule

// File: rtl/psa_modexp.sv
module psa_modexp
  import psa_pkg::*;
#(
  parameter int W  = 8,
  parameter int M  = 8,
  parameter int LW = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  msg,
  input  logic [M-1:0]  expo,
  input  logic [W-1:0]  modulus,
  input  logic [LW-1:0] seed,
  output logic          done,
  output logic [W-1:0]  result,
  output logic          mul_tick
);
  localparam int IW = (M > 1) ? $clog2(M) : 1;
  localparam int CW = IW + 1;

  state_t        st;
  logic [W-1:0]  a_q, p_q, sq_q, acc_q, tbl_rd;
  logic [M-1:0]  x_q;
  logic [IW-1:0] i_q;
  logic [CW-1:0] k_q;
  logic [IW-1:0] perm [M];
  logic [W-1:0]  tbl  [M];

  logic          accept_start;
  logic          mul_go, mul_rdy;
  logic [W-1:0]  mul_a, mul_b, mul_y;
  logic [LW-1:0] lf_q;
  logic [IW-1:0] cand;
  logic          cand_ok, scan_bit;
  logic [IW-1:0] one_dout, zero_dout;
  logic [CW-1:0] cnt1, cnt0;

  function automatic logic [IW-1:0] smear(input logic [IW-1:0] v);
    logic [IW-1:0] s;
    s = v;
    for (int b = 1; b < IW; b++) s = s | (s >> b);
    return s;
  endfunction

  assign accept_start = start && (st == S_IDLE);
  assign cand     = lf_q[IW-1:0] & smear(i_q);
  assign cand_ok  = (cand <= i_q);
  assign scan_bit = x_q[perm[i_q]];

  assign mul_go = (st == S_PRE_GO) || (st == S_ACC_MUL);
  assign mul_a  = (st == S_ACC_MUL) ? acc_q : ((i_q == '0) ? W'(1) : sq_q);
  assign mul_b  = (st == S_ACC_MUL) ? tbl_rd : ((i_q == '0) ? a_q : sq_q);

  psa_lfsr #(.LW(LW), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst(rst), .load(accept_start), .seed(seed),
    .step(st == S_SHUF), .q(lf_q)
  );

  psa_modmul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .a(mul_a), .b(mul_b), .p(p_q),
    .y(mul_y), .rdy(mul_rdy)
  );

  psa_idxlist #(.DEPTH(M), .AW(IW)) u_ones (
    .clk(clk), .rst(rst), .clr(accept_start),
    .push(st == S_SCAN && scan_bit), .din(i_q),
    .rd_addr(k_q[IW-1:0]), .rd_data(one_dout), .count(cnt1)
  );

  psa_idxlist #(.DEPTH(M), .AW(IW)) u_zeros (
    .clk(clk), .rst(rst), .clr(accept_start),
    .push(st == S_SCAN && !scan_bit), .din(i_q),
    .rd_addr('0), .rd_data(zero_dout), .count(cnt0)
  );

  // power table: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (st == S_PRE_WAIT && mul_rdy) tbl[i_q] <= mul_y;
    tbl_rd <= tbl[perm[one_dout]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; done <= 1'b0; result <= '0; mul_tick <= 1'b0;
      a_q <= '0; p_q <= '0; x_q <= '0; sq_q <= '0; acc_q <= '0;
      i_q <= '0; k_q <= '0;
      for (int g = 0; g < M; g++) perm[g] <= IW'(g);
    end else begin
      done     <= 1'b0;
      mul_tick <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          a_q <= msg; x_q <= expo; p_q <= modulus; i_q <= '0;
          for (int g = 0; g < M; g++) perm[g] <= IW'(g);
          st <= S_PRE_GO;
        end
        S_PRE_GO: st <= S_PRE_WAIT;
        S_PRE_WAIT: if (mul_rdy) begin
          sq_q <= mul_y;
          if (i_q == IW'(M - 1)) st <= S_SHUF;
          else begin
            i_q <= i_q + 1'b1;
            st  <= S_PRE_GO;
          end
        end
        S_SHUF: if (cand_ok) begin
          perm[i_q]  <= perm[cand];
          perm[cand] <= perm[i_q];
          if (i_q == IW'(1)) begin
            i_q <= '0;
            st  <= S_SCAN;
          end else i_q <= i_q - 1'b1;
        end
        S_SCAN: begin
          if (i_q == IW'(M - 1)) begin
            k_q <= '0; acc_q <= W'(1); st <= S_ACC_RD;
          end else i_q <= i_q + 1'b1;
        end
        S_ACC_RD:  st <= (k_q == cnt1) ? S_FIN : S_ACC_TB;
        S_ACC_TB:  st <= S_ACC_MUL;
        S_ACC_MUL: st <= S_ACC_WAIT;
        S_ACC_WAIT: if (mul_rdy) begin
          acc_q <= mul_y; k_q <= k_q + 1'b1; mul_tick <= 1'b1;
          st <= S_ACC_RD;
        end
        S_FIN: begin
          result <= acc_q; done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psa_modexp_chk.sv
module psa_modexp_chk
  import psa_pkg::*;
#(
  parameter int W = 8,
  parameter int M = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input state_t        st,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] k_q,
  input logic          mul_tick,
  input logic          done,
  input logic [W-1:0]  result,
  input logic [W-1:0]  p_q
);
  // R4: compaction covered every permuted position exactly once
  a_r4_lists_cover_all: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACC_RD && k_q == '0) |-> ({1'b0, cnt1} + {1'b0, cnt0}) == (CW+1)'(M));

  // R4: never more accumulation multiplies than one-list entries
  a_r4_tick_bounded: assert property (@(posedge clk) disable iff (rst)
    mul_tick |-> (k_q <= cnt1));

  // R5: an empty one-list goes straight to completion
  a_r5_empty_skip: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACC_RD && k_q == '0 && cnt1 == '0) |=> (st == S_FIN && !mul_tick));

  // R6: completion is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a start during a run does not return the block to idle
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && st != S_IDLE && st != S_FIN) |=> (st != S_IDLE));

  // R8: result reduced below the captured modulus
  a_r8_result_in_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < p_q));
endmodule

bind psa_modexp psa_modexp_chk #(.W(W), .M(M), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .st(st), .cnt1(cnt1), .cnt0(cnt0),
  .k_q(k_q), .mul_tick(mul_tick), .done(done), .result(result), .p_q(p_q)
);

// File: tb/tb_psa_modexp.sv
`timescale 1ns/1ps
module tb_psa_modexp;
  localparam int W = 8, M = 8, LW = 16;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [W-1:0]  msg = '0, modulus = 8'd2;
  logic [M-1:0]  expo = '0;
  logic [LW-1:0] seed = '0;
  logic          done, mul_tick;
  logic [W-1:0]  result;

  int  vecs = 0, errs = 0, ticks = 0;
  bit  in_run = 1'b0;

  always #2.5 clk = ~clk;

  psa_modexp #(.W(W), .M(M), .LW(LW)) dut (
    .clk(clk), .rst(rst), .start(start), .msg(msg), .expo(expo),
    .modulus(modulus), .seed(seed), .done(done), .result(result),
    .mul_tick(mul_tick)
  );

  function automatic int ref_exp(int a, int x, int p);
    int r = 1 % p;
    int b = a % p;
    for (int i = 0; i < M; i++) begin
      if ((x >> i) & 1) r = (r * b) % p;
      b = (b * b) % p;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-clock monitor: activity only inside a run (R4, R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (mul_tick) begin
        ticks++;
        if (!in_run) check(1'b0, "R4 stray tick", 1, 0);
      end
      if (done && !in_run) check(1'b0, "R6 stray done", 1, 0);
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [M-1:0] x,
                     input logic [W-1:0] p, input logic [LW-1:0] s,
                     input bit poke, input string req);
    int cyc = 0;
    int exp_r = ref_exp(int'(a), int'(x), int'(p));
    @(negedge clk);
    msg = a; expo = x; modulus = p; seed = s; start = 1'b1;
    ticks = 0; in_run = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 20) begin
        start = 1'b1; expo = ~x; msg = a + 8'd1; seed = ~s;
      end else start = 1'b0;
    end
    start = 1'b0;
    if (!done) check(1'b0, {req, " watchdog"}, cyc, 0);
    else begin
      check(int'(result) == exp_r, req, int'(result), exp_r);
      check(ticks == $countones(x), "R4 tick count", ticks, $countones(x));
      check(result < p, "R8 range", int'(result), int'(p));
    end
    @(negedge clk);
    in_run = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(mul_tick == 1'b0, "R1 tick", int'(mul_tick), 0);
    check(result == '0, "R1 result", int'(result), 0);
    rst = 1'b0;

    run(8'd5, 8'h00, 8'd13, 16'h0001, 1'b0, "R5 zero exponent");
    check(result == 8'd1, "R5 value", int'(result), 1);
    run(8'd3, 8'hFF, 8'd251, 16'h1357, 1'b0, "R2 all ones");
    run(8'd200, 8'h81, 8'd7, 16'h2222, 1'b0, "R2 base above modulus");
    run(8'd255, 8'h37, 8'd2, 16'h00FF, 1'b0, "R2 modulus two");
    run(8'd0, 8'h04, 8'd97, 16'h4242, 1'b0, "R2 zero base");

    foreach (seed[i]) begin
      run(8'd17, 8'hA5, 8'd229, 16'(1 << i), 1'b0, "R3 seed sweep");
    end
    run(8'd17, 8'hA5, 8'd229, 16'h0000, 1'b0, "R3 zero seed");

    for (int b = 0; b < M; b++) begin
      run(8'd11, 8'(1 << b), 8'd241, 16'(b * 77 + 5), 1'b0, "R4 single bit");
    end

    run(8'd9, 8'h6C, 8'd199, 16'hACE1, 1'b1, "R7 start while busy");
    held = result;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done) check(1'b0, "R7 extra done", 1, 0);
    end
    check(result == held, "R6 result held", int'(result), int'(held));

    for (int n = 0; n < 30; n++) begin
      logic [W-1:0] p;
      p = 8'($urandom_range(2, 255));
      run(8'($urandom), 8'($urandom), p, 16'($urandom), 1'b0, "R2 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule